// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a general-purpose timer. A 16-bit up-counter runs freely from a count clock. That count clock is derived from the bus clock in two stages. A source stage passes the bus clock straight through or divides it by sixteen. An 8-bit programmable prescaler then divides the result again.

The host loads a reference value into the block. When the counter matches it, the block records a sticky event flag and can raise an interrupt. It also drives an active-low timer pin, which gives either a single low pulse or a level change. A chain of such events can therefore produce a periodic waveform.

The counter either wraps at the top of its range or restarts from zero on every match. A write to the counter restarts the whole time base. A run input freezes all timing when it is low.

A match event happens on the count tick that moves the counter off the reference value. At that tick, the counter holds the reference value.

Top module: `prescaled_compare_timer`

## Requirements
- R1: After reset the count is 0, the event flag is 0, the interrupt is 0, the timer pin is 1 and the reference value is 0xFFFF.
- R2: With `src_div16` at 0, the source stage gives one tick per bus clock. With it at 1, it gives one tick every 16 bus clocks. After a counter write, the first divided tick comes on the 16th clock.
- R3: A prescale value N yields one count tick per N+1 source ticks, so a value of 0 passes every source tick through.
- R4: With restart disabled, each count tick adds one to the counter, and 0xFFFF is followed by 0x0000.
- R5: A match event is a count tick taken while the count equals the reference. With `restart_en` at 1, that tick loads 0 instead of count+1.
- R6: A match event sets the event flag one clock later. The flag holds until a clock with `flag_clr` at 1. If both happen in the same clock, setting wins.
- R7: `irq` is 1 exactly while both the event flag and `irq_en` are 1.
- R8: With `out_toggle` at 0 (pulse mode), the pin goes low the clock after a match event. It returns high the clock after the next count tick that is not itself a match event, so one count period low.
- R9: With `out_toggle` at 1 (toggle mode), the pin inverts the clock after each match event and otherwise holds.
- R10: A clock with `cnt_wr` at 1 sets the count, the prescaler phase and the source-divider phase to zero. No count tick or match event is taken in that clock.
- R11: While `run` is 0 (and no counter write), the count and both divider phases hold.
- R12: A clock with `ref_wr` at 1 loads `ref_wdata` as the new reference. The old reference applies to that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | synchronous active-low reset |
| run | input | 1 | enables the time base |
| src_div16 | input | 1 | 0: bus clock, 1: bus clock / 16 |
| prescale | input | 8 | prescaler value N, divides by N+1 |
| restart_en | input | 1 | clear counter on match |
| out_toggle | input | 1 | 0: pulse pin, 1: toggle pin |
| irq_en | input | 1 | interrupt enable |
| ref_wr | input | 1 | reference write strobe |
| ref_wdata | input | 16 | reference write data |
| cnt_wr | input | 1 | counter write strobe (clears time base) |
| flag_clr | input | 1 | write-one-to-clear for the event flag |
| count | output | 16 | current counter value |
| match_flag | output | 1 | sticky compare event flag |
| irq | output | 1 | interrupt request |
| tmr_out_n | output | 1 | active-low timer pin |

## Verification
The assertions watch relations that hold in every clock:
- the counter only steps by one or drops to zero;
- a counter write zeroes it;
- a stopped timer holds its count;
- the flag is sticky;
- the interrupt never stands without the flag;
- a falling pin edge in pulse mode, or any pin change in toggle mode, comes with the flag set.

Only the bench's scenarios can show the exact rates set by the source stage and the prescaler, the wrap from 0xFFFF, the restart point, and the width of the low pulse. The same holds for the reference taking effect, since those depend on counting many clocks against a model.

// File: rtl/pct_pkg.sv
// Package: shared widths and the pin mode type for the prescaled compare timer.
// Assumes: nothing beyond IEEE 1800-2017.
package pct_pkg;
    localparam int unsigned CNT_W   = 16;
    localparam int unsigned PSC_W   = 8;
    localparam int unsigned SRC_DIV = 16;

    typedef enum logic {
        PIN_PULSE  = 1'b0,
        PIN_TOGGLE = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/pct_src_divider.sv
// Module: source stage. Emits a tick every bus clock, or one every DIV clocks.
// Assumes: DIV >= 2; clear has priority and suppresses the tick.
module pct_src_divider #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic sel_div,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // phase counter of the divided source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear || !sel_div) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // tick whenever the selected source completes a period
    always_comb begin
        tick = run && !clear && (sel_div ? (phase_q == LAST) : 1'b1);
    end
endmodule

// File: rtl/pct_prescaler.sv
// Module: programmable prescaler. Passes one of every limit+1 source ticks.
// Assumes: a limit lowered below the current phase ends the period at once.
module pct_prescaler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         src_tick,
    input  logic [W-1:0] limit,
    output logic         cnt_tick
);
    logic [W-1:0] phase_q;
    logic         wrap;

    // end of a prescaler period
    always_comb begin
        wrap     = (phase_q >= limit);
        cnt_tick = src_tick && wrap;
    end

    // prescaler phase, advanced by source ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (src_tick) begin
            phase_q <= wrap ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/pct_compare_counter.sv
// Module: free-running counter with reference register and match detection.
// Assumes: the match is taken on a count tick while count equals the reference.
module pct_compare_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         cnt_tick,
    input  logic         restart_en,
    input  logic         ref_wr,
    input  logic [W-1:0] ref_wdata,
    output logic [W-1:0] count,
    output logic         match_evt
);
    logic [W-1:0] count_q;
    logic [W-1:0] ref_q;

    // match event: tick while sitting on the reference
    always_comb begin
        match_evt = cnt_tick && (count_q == ref_q);
        count     = count_q;
    end

    // counter register: clear, restart or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (cnt_tick) begin
            count_q <= (match_evt && restart_en) ? '0 : count_q + 1'b1;
        end
    end

    // reference register written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '1;
        end else if (ref_wr) begin
            ref_q <= ref_wdata;
        end
    end
endmodule

// File: rtl/pct_event_out.sv
// Module: sticky event flag, interrupt gate and timer pin shaping.
// Assumes: match_evt and cnt_tick are single-clock strobes from the counter path.
module pct_event_out
    import pct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      match_evt,
    input  logic      cnt_tick,
    input  logic      flag_clr,
    input  logic      irq_en,
    input  pin_mode_e mode,
    output logic      match_flag,
    output logic      irq,
    output logic      pin_n
);
    logic flag_q;
    logic pulse_q;
    logic level_q;

    // sticky flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match_evt) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // pulse window lasting one count period after a match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else if (match_evt) begin
            pulse_q <= 1'b1;
        end else if (cnt_tick) begin
            pulse_q <= 1'b0;
        end
    end

    // toggle level inverted on each match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else if (match_evt) begin
            level_q <= ~level_q;
        end
    end

    // output selection
    always_comb begin
        match_flag = flag_q;
        irq        = flag_q && irq_en;
        pin_n      = (mode == PIN_TOGGLE) ? level_q : ~pulse_q;
    end
endmodule

// File: rtl/prescaled_compare_timer.sv
// Module: top of the prescaled compare timer.
// Chain: source stage -> prescaler -> counter/compare -> flag and pin.
// Assumes: host strobes are single-clock and synchronous to clk.
module prescaled_compare_timer
    import pct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              src_div16,
    input  logic [PSC_W-1:0]  prescale,
    input  logic              restart_en,
    input  logic              out_toggle,
    input  logic              irq_en,
    input  logic              ref_wr,
    input  logic [CNT_W-1:0]  ref_wdata,
    input  logic              cnt_wr,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              match_flag,
    output logic              irq,
    output logic              tmr_out_n
);
    logic      src_tick;
    logic      cnt_tick;
    logic      match_evt;
    pin_mode_e pin_mode;

    // decode the pin mode input
    always_comb begin
        pin_mode = out_toggle ? PIN_TOGGLE : PIN_PULSE;
    end

    pct_src_divider #(.DIV(SRC_DIV)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clear   (cnt_wr),
        .sel_div (src_div16),
        .tick    (src_tick)
    );

    pct_prescaler #(.W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_wr),
        .src_tick (src_tick),
        .limit    (prescale),
        .cnt_tick (cnt_tick)
    );

    pct_compare_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cnt_wr),
        .cnt_tick   (cnt_tick),
        .restart_en (restart_en),
        .ref_wr     (ref_wr),
        .ref_wdata  (ref_wdata),
        .count      (count),
        .match_evt  (match_evt)
    );

    pct_event_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_evt  (match_evt),
        .cnt_tick   (cnt_tick),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .mode       (pin_mode),
        .match_flag (match_flag),
        .irq        (irq),
        .pin_n      (tmr_out_n)
    );
endmodule

// File: rtl/pct_checker.sv
// Module: port-level properties of the prescaled compare timer, bound to the top.
module pct_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        out_toggle,
    input logic        irq_en,
    input logic        cnt_wr,
    input logic        flag_clr,
    input logic [15:0] count,
    input logic        match_flag,
    input logic        irq,
    input logic        tmr_out_n
);
    // R4 and R5: the counter only steps by one or falls to zero
    a_r4_step_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == $past(count) + 16'd1) || (count == 16'd0));

    // R10: a counter write zeroes the count
    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == 16'd0));

    // R11: stopped timer holds its count
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    // R6: the flag stays set without a clear
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);

    // R7: no interrupt without the flag and enable
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && irq_en));

    // R8: a low pulse starts only with a fresh event
    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_toggle && $past(!out_toggle) && $fell(tmr_out_n)) |-> match_flag);

    // R9: the toggled pin moves only with an event
    a_r9_toggle_event: assert property (@(posedge clk) disable iff (!rst_n)
        (out_toggle && $past(out_toggle) && !$stable(tmr_out_n)) |-> match_flag);
endmodule

bind prescaled_compare_timer pct_checker u_pct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .out_toggle (out_toggle),
    .irq_en     (irq_en),
    .cnt_wr     (cnt_wr),
    .flag_clr   (flag_clr),
    .count      (count),
    .match_flag (match_flag),
    .irq        (irq),
    .tmr_out_n  (tmr_out_n)
);

// File: tb/prescaled_compare_timer_bench.sv
// Bench: behavioural model compared every clock, plus directed scenarios.
module prescaled_compare_timer_bench;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        src_div16 = 1'b0;
    logic [7:0]  prescale = 8'd0;
    logic        restart_en = 1'b0;
    logic        out_toggle = 1'b0;
    logic        irq_en = 1'b0;
    logic        ref_wr = 1'b0;
    logic [15:0] ref_wdata = 16'd0;
    logic        cnt_wr = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] count;
    logic        match_flag;
    logic        irq;
    logic        tmr_out_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    int m_src = 0, m_psc = 0, m_cnt = 0, m_ref = 65535;
    bit m_flag = 0, m_pulse = 0, m_lvl = 1;

    always #(CLK_P/2) clk = ~clk;

    prescaled_compare_timer u_prescaled_compare_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .src_div16(src_div16),
        .prescale(prescale), .restart_en(restart_en), .out_toggle(out_toggle),
        .irq_en(irq_en), .ref_wr(ref_wr), .ref_wdata(ref_wdata),
        .cnt_wr(cnt_wr), .flag_clr(flag_clr), .count(count),
        .match_flag(match_flag), .irq(irq), .tmr_out_n(tmr_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit src_t, tick, ev;
        if (!rst_n) begin
            m_src = 0; m_psc = 0; m_cnt = 0; m_ref = 65535;
            m_flag = 0; m_pulse = 0; m_lvl = 1;
        end else begin
            tick = 0; src_t = 0;
            if (cnt_wr) begin
                m_src = 0; m_psc = 0; m_cnt = 0;
            end else begin
                if (!src_div16) m_src = 0;
                if (run) begin
                    if (src_div16) begin
                        src_t = (m_src == 15);
                        m_src = (m_src + 1) % 16;
                    end else begin
                        src_t = 1;
                    end
                end
                if (src_t) begin
                    if (m_psc >= int'(prescale)) begin tick = 1; m_psc = 0; end
                    else m_psc++;
                end
            end
            ev = tick && (m_cnt == m_ref);
            if (tick) m_cnt = (ev && restart_en) ? 0 : (m_cnt + 1) % 65536;
            if (ev) m_pulse = 1; else if (tick) m_pulse = 0;
            if (ev) m_lvl = !m_lvl;
            if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
            if (ref_wr) m_ref = int'(ref_wdata);
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R3 R4 R5 R10 R11 count", int'(count), m_cnt);
            check("R6 flag", int'(match_flag), int'(m_flag));
            check("R7 irq", int'(irq), int'(m_flag && irq_en));
            check("R8 R9 pin", int'(tmr_out_n), out_toggle ? int'(m_lvl) : int'(!m_pulse));
        end
    end

    task automatic cycles(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic clear_cnt();
        cnt_wr = 1'b1; cycles(1); cnt_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; cycles(1); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 190000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int held;
        cycles(3);
        rst_n = 1'b1;
        check("R1 count", int'(count), 0);
        check("R1 flag", int'(match_flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 pin", int'(tmr_out_n), 1);

        // R12 and R5: reference 5 with restart, every clock a tick
        ref_wdata = 16'd5; ref_wr = 1'b1; cycles(1); ref_wr = 1'b0;
        restart_en = 1'b1; irq_en = 1'b1; run = 1'b1;
        clear_cnt();
        cycles(5);
        check("R12 count at ref", int'(count), 5);
        check("R6 flag before match", int'(match_flag), 0);
        cycles(1);
        check("R5 restart to zero", int'(count), 0);
        check("R6 flag set", int'(match_flag), 1);
        check("R7 irq raised", int'(irq), 1);
        check("R8 pin low", int'(tmr_out_n), 0);
        cycles(1);
        check("R8 pin high after one period", int'(tmr_out_n), 1);
        irq_en = 1'b0; cycles(1);
        check("R7 irq masked", int'(irq), 0);
        clear_flag();
        check("R6 flag cleared", int'(match_flag), 0);
        irq_en = 1'b1;

        // pulse mode with a slow prescaler, then toggle mode
        prescale = 8'd2; cycles(60);
        out_toggle = 1'b1; prescale = 8'd3; cycles(100);
        out_toggle = 1'b0;

        // R3: prescale 3 gives one count per four clocks
        restart_en = 1'b0; ref_wdata = 16'hFFFF; ref_wr = 1'b1; cycles(1); ref_wr = 1'b0;
        clear_cnt(); cycles(40);
        check("R3 prescale 3 rate", int'(count), 10);

        // R2: divide by 16, prescale 1
        src_div16 = 1'b1; prescale = 8'd1;
        clear_cnt(); cycles(96);
        check("R2 div16 rate", int'(count), 3);

        // R11: stop holds the count
        run = 1'b0; held = int'(count); cycles(20);
        check("R11 held count", int'(count), held);
        run = 1'b1; cycles(7);

        // R10: a counter write clears the time base
        clear_cnt();
        check("R10 count cleared", int'(count), 0);

        // toggle mode under divide by 16 with frequent matches
        out_toggle = 1'b1; restart_en = 1'b1; prescale = 8'd0;
        ref_wdata = 16'd2; ref_wr = 1'b1; cycles(1); ref_wr = 1'b0;
        cycles(300);

        // R4: wrap from 0xFFFF with restart off
        out_toggle = 1'b0; restart_en = 1'b0; src_div16 = 1'b0; prescale = 8'd0;
        ref_wdata = 16'hFFFF; ref_wr = 1'b1; cycles(1); ref_wr = 1'b0;
        clear_cnt(); clear_flag();
        clear_cnt();
        cycles(65535);
        check("R4 top value", int'(count), 16'hFFFF);
        cycles(1);
        check("R4 wrap to zero", int'(count), 0);
        check("R6 flag at wrap match", int'(match_flag), 1);
        cycles(5);
        finish_run();
    end
endmodule